// File: doc/BRIEF.md
# Indexed Register Access Port

This block gives a host a two-location window onto a bank of 32 indirect 8-bit registers. Location 0 holds an index byte. The index byte names one indirect register and carries three control flags. Location 1 reads or writes the register that the current index names. Reads have no side effects. Read data is combinational from the current state, so a read returns the selected register in the same cycle. A write strobe is sampled on the rising clock edge.

The index byte also carries several control flags:
- A read-only busy flag. It is set while the block initializes after reset, and while a power-down input is held.
- A mode-change flag. It drives a mute output, and it guards two format registers against writes.
- A transfer-disable flag. It is brought out on a port of its own.

The fifth index bit reaches the upper sixteen registers only in extended mode. While busy, both locations refuse writes and read back a fixed pattern.

Top module: `idx_reg_port`

## Requirements
- R1: After reset is released, `busy` stays 1 for exactly INIT_CYCLES rising edges and then falls to 0. While `busy` is 1, both locations read 8'h80.
- R2: While `busy` is 1, writes to the index location and to the data location change no state.
- R3: Once initialization has ended after reset, the index location reads 8'h40: mode-change set, transfer-disable clear, index 0.
- R4: The index byte has bit 7 = busy (read-only), bit 6 = mode-change, bit 5 = transfer-disable, and bits 4..0 = index. A write to bit 7 has no effect.
- R5: Index bits 3..0 select one of 16 indirect registers. A data-location write stores into the selected register. A data-location read returns it in the same cycle.
- R6: With `ext_mode` = 1, index bit 4 selects registers 16 to 31, which are distinct from registers 0 to 15.
- R7: With `ext_mode` = 0, index bit 4 does not affect addressing, and it reads back as 0.
- R8: `mute` equals the mode-change bit (index bit 6).
- R9: `xfer_dis` equals the transfer-disable bit (index bit 5).
- R10: Indirect register 8 is the format register. With mode-change clear, a write to it is dropped and `wr_err` is high for the one cycle after the write. With mode-change set, the write is stored and `wr_err` stays 0.
- R11: Indirect register 9 is the configuration register. With mode-change clear, only its bits 1..0 take the written value. The other bits keep their old value, and `wr_err` pulses if any of those other bits would have changed.
- R12: While `pwr_down` is 1, `busy` is 1. On release, `busy` stays 1 for INIT_CYCLES more edges. The index and the indirect registers keep their contents across the power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Forces the busy state while high |
| ext_mode | input | 1 | 1 = extended mode, with a 5-bit index |
| host_sel | input | 1 | 0 = index location, 1 = data location |
| host_wr | input | 1 | Write strobe, sampled on the clock edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected location |
| busy | output | 1 | Initialization or power-down in progress |
| mute | output | 1 | Output mute, follows mode-change |
| xfer_dis | output | 1 | Transfer-request disable flag |
| wr_err | output | 1 | One-cycle pulse for a protected write that was refused |

## Verification
The bench builds the block with INIT_CYCLES = 4. This keeps the busy windows after reset and after power-down short enough to count edge by edge. The full 8-bit data width and the 5-bit index are kept. As a result, both the extended-mode upper bank and the mode-1 aliasing of index bit 4 are reached in the same run. The default format and configuration register positions put both protected registers within the lower sixteen, so they are reached in either mode.

// File: rtl/idxp_pkg.sv
package idxp_pkg;
    localparam int DW      = 8;
    localparam int IDX_W   = 5;
    localparam int NREG    = 1 << IDX_W;
    localparam logic [DW-1:0] BUSY_PATTERN = 8'h80;

    typedef struct packed {
        logic             mce;
        logic             trd;
        logic [IDX_W-1:0] idx;
    } idx_t;

    localparam idx_t IDX_RESET = '{mce: 1'b1, trd: 1'b0, idx: '0};
endpackage

// File: rtl/idxp_init_ctrl.sv
module idxp_init_ctrl #(
    parameter int INIT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    output logic busy
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(INIT_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (pwr_down) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_LOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = pwr_down || (cnt_q != '0);
endmodule

// File: rtl/idxp_reg_bank.sv
module idxp_reg_bank
    import idxp_pkg::*;
#(
    parameter int          FMT_IDX  = 8,
    parameter int          CFG_IDX  = 9,
    parameter logic [DW-1:0] CFG_FREE = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    input  logic             mce,
    output logic [DW-1:0]    rdata,
    output logic             err
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic                    err;
    } bank_t;

    bank_t st_d, st_q;
    logic [NREG-1:0] is_fmt, is_cfg;

    for (genvar g = 0; g < NREG; g++) begin : g_prot
        assign is_fmt[g] = (g == FMT_IDX);
        assign is_cfg[g] = (g == CFG_IDX);
    end

    always_comb begin
        logic [DW-1:0] cur;
        logic [DW-1:0] lost;
        st_d     = st_q;
        st_d.err = 1'b0;
        cur      = st_q.regs[addr];
        lost     = (wdata ^ cur) & ~CFG_FREE;
        if (we) begin
            if (mce || (!is_fmt[addr] && !is_cfg[addr])) begin
                st_d.regs[addr] = wdata;
            end else if (is_cfg[addr]) begin
                st_d.regs[addr] = (cur & ~CFG_FREE) | (wdata & CFG_FREE);
                st_d.err        = |lost;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.regs[addr];
    assign err   = st_q.err;
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
    import idxp_pkg::*;
#(
    parameter int INIT_CYCLES = 64,
    parameter int FMT_IDX     = 8,
    parameter int CFG_IDX     = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down,
    input  logic          ext_mode,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          busy,
    output logic          mute,
    output logic          xfer_dis,
    output logic          wr_err
);
    idx_t idx_d, idx_q;
    logic [IDX_W-1:0] eff_idx;
    logic [DW-1:0]    bank_rdata;
    logic [DW-1:0]    idx_byte;
    logic             bank_we;

    idxp_init_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .busy     (busy)
    );

    always_comb begin
        idx_d = idx_q;
        if (host_wr && !host_sel && !busy) begin
            idx_d.mce = host_wdata[6];
            idx_d.trd = host_wdata[5];
            idx_d.idx = host_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= IDX_RESET;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign eff_idx  = {ext_mode & idx_q.idx[IDX_W-1], idx_q.idx[IDX_W-2:0]};
    assign idx_byte = {busy, idx_q.mce, idx_q.trd, eff_idx};
    assign bank_we  = host_wr && host_sel && !busy;

    idxp_reg_bank #(.FMT_IDX(FMT_IDX), .CFG_IDX(CFG_IDX)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .addr  (eff_idx),
        .wdata (host_wdata),
        .mce   (idx_q.mce),
        .rdata (bank_rdata),
        .err   (wr_err)
    );

    assign host_rdata = busy ? BUSY_PATTERN : (host_sel ? bank_rdata : idx_byte);
    assign mute       = idx_q.mce;
    assign xfer_dis   = idx_q.trd;
endmodule

// File: rtl/idxp_chk.sv
module idxp_chk
    import idxp_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_down,
    input logic          ext_mode,
    input logic          host_sel,
    input logic          host_wr,
    input logic [DW-1:0] host_rdata,
    input logic          busy,
    input logic          mute,
    input logic          wr_err,
    input idx_t          idx_q
);
    // R1
    busy_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> host_rdata == BUSY_PATTERN);
    // R2
    busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr) |=> idx_q == $past(idx_q));
    // R8
    mute_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !host_sel) |-> mute == host_rdata[6]);
    // R7
    mode1_bit4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !host_sel && !ext_mode) |-> host_rdata[4] == 1'b0);
    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(host_wr && host_sel && !busy && !mute));
    // R12
    pd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> busy);
endmodule

bind idx_reg_port idxp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .ext_mode   (ext_mode),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rdata (host_rdata),
    .busy       (busy),
    .mute       (mute),
    .wr_err     (wr_err),
    .idx_q      (idx_q)
);

// File: tb/tb_idx_reg_port.sv
module tb_idx_reg_port;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_N     = 4;

    typedef struct packed {
        logic       wsel;
        logic [7:0] wd;
        logic       rsel;
        logic [7:0] exp;
        logic       eerr;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h45, 1'b0, 8'h45, 1'b0, 4'd4},  // R4 index write
        '{1'b1, 8'hA5, 1'b1, 8'hA5, 1'b0, 4'd5},  // R5 data reg 5
        '{1'b0, 8'hC6, 1'b0, 8'h46, 1'b0, 4'd4},  // R4 bit7 read-only
        '{1'b1, 8'h3C, 1'b1, 8'h3C, 1'b0, 4'd5},  // R5 data reg 6
        '{1'b0, 8'h45, 1'b1, 8'hA5, 1'b0, 4'd5},  // R5 reselect reg 5
        '{1'b0, 8'h55, 1'b1, 8'h00, 1'b0, 4'd6},  // R6 reg 21 empty
        '{1'b1, 8'h77, 1'b1, 8'h77, 1'b0, 4'd6},  // R6 write reg 21
        '{1'b0, 8'h45, 1'b1, 8'hA5, 1'b0, 4'd6},  // R6 reg 5 untouched
        '{1'b0, 8'h08, 1'b0, 8'h08, 1'b0, 4'd4},  // R4 mce clear, reg 8
        '{1'b1, 8'hFF, 1'b1, 8'h00, 1'b1, 4'd10}, // R10 dropped
        '{1'b0, 8'h09, 1'b0, 8'h09, 1'b0, 4'd4},  // R4 reg 9
        '{1'b1, 8'hF3, 1'b1, 8'h03, 1'b1, 4'd11}, // R11 free bits only
        '{1'b0, 8'h48, 1'b0, 8'h48, 1'b0, 4'd4},  // R4 mce set, reg 8
        '{1'b1, 8'h5A, 1'b1, 8'h5A, 1'b0, 4'd10}, // R10 allowed
        '{1'b0, 8'h29, 1'b0, 8'h29, 1'b0, 4'd9}   // R9 trd set
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       ext_mode = 1'b1;
    logic       host_sel = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       busy, mute, xfer_dis, wr_err;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_reg_port #(.INIT_CYCLES(INIT_N)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .ext_mode(ext_mode),
        .host_sel(host_sel), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .mute(mute),
        .xfer_dis(xfer_dis), .wr_err(wr_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_chk(input logic sel, input logic [7:0] exp, input string req);
        host_sel = sel;
        #1;
        check(req, host_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1 both locations read pattern while busy
        read_chk(1'b0, 8'h80, "R1");
        read_chk(1'b1, 8'h80, "R1");
        repeat (INIT_N - 1) @(posedge clk);
        #1 check("R1", {7'd0, busy}, 8'd1);
        @(posedge clk);
        #1 check("R1", {7'd0, busy}, 8'd0);
        // R3 reset value
        @(negedge clk);
        read_chk(1'b0, 8'h40, "R3");
        check("R8", {7'd0, mute}, 8'd1);
        check("R9", {7'd0, xfer_dis}, 8'd0);

        // table walk, extended mode
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            do_write(VECS[i].wsel, VECS[i].wd);
            check({tag, " err"}, {7'd0, wr_err}, {7'd0, VECS[i].eerr});
            read_chk(VECS[i].rsel, VECS[i].exp, tag);
        end
        check("R8", {7'd0, mute}, 8'd0);
        check("R9", {7'd0, xfer_dis}, 8'd1);

        // R7 mode 1: bit4 ignored and reads 0
        ext_mode = 1'b0;
        do_write(1'b0, 8'h55);
        read_chk(1'b0, 8'h45, "R7");
        read_chk(1'b1, 8'hA5, "R7");
        ext_mode = 1'b1;
        read_chk(1'b1, 8'h77, "R6");

        // R12 power-down, with R2 ignored writes
        do_write(1'b0, 8'h45);
        @(negedge clk);
        pwr_down = 1'b1;
        #1 check("R12", {7'd0, busy}, 8'd1);
        read_chk(1'b0, 8'h80, "R12");
        do_write(1'b0, 8'h4A);
        do_write(1'b1, 8'h11);
        check("R2", {7'd0, wr_err}, 8'd0);
        @(negedge clk);
        pwr_down = 1'b0;
        repeat (INIT_N - 1) @(posedge clk);
        #1 check("R12", {7'd0, busy}, 8'd1);
        @(posedge clk);
        #1 check("R12", {7'd0, busy}, 8'd0);
        @(negedge clk);
        read_chk(1'b0, 8'h45, "R2");
        read_chk(1'b1, 8'hA5, "R12");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule